// File: doc/BRIEF.md
# Selectable-Rate Clock-Enable Generator

This block turns one fixed base clock into a clock-enable pulse train, so that logic gated by the enable runs at a chosen average rate without a second clock domain. Four rates are offered. Each rate is a number of enabled cycles in every 20-cycle frame of the base clock. A phase accumulator spreads the few suppressed cycles across the frame, so the enable drops for single cycles and never for a long stretch. The average rate is exact over a frame, but the spacing between pulses varies from cycle to cycle.

Software writes a 2-bit rate code through a one-cycle write strobe. The code is not used at once. It waits as a pending value until the downstream logic reports idle on the last cycle of a frame. At that point the new rate is loaded and an acknowledge pulse marks the first cycle that runs at it. The active code is always visible on an output.

Top module: `rate_enable_gen`

## Requirements
- R1: A synchronous active-high reset selects code 00, clears the accumulator, the frame position and any pending code, and holds the acknowledge low. In the first cycle after reset `tick` is 0.
- R2: The rate code is encoded as 00 = 10, 01 = 13, 10 = 16 and 11 = 19 enabled cycles per 20-cycle frame. With a 100 MHz base clock these give 50, 65, 80 and 95 MHz.
- R3: `tick` is high in a cycle exactly when the accumulator plus the active count reaches 20. The accumulator then keeps that sum minus 20, or keeps the plain sum when no pulse is given. As a result, two low `tick` cycles never occur back to back.
- R4: A write stores its code as pending. A later write before the commit replaces it. Once a code is committed, nothing stays pending unless a new write has arrived.
- R5: A pending code becomes active only at the end of the last cycle of a frame (position 19) while `idle` is high. While `idle` is low, `rate_cur` does not change and no acknowledge is given.
- R6: `upd_ack` is high for exactly one cycle, which is the first cycle of the frame that runs at the newly loaded code. In that same cycle `rate_cur` shows the new code.
- R7: If a write arrives in the same cycle as a commit, the older pending code is the one committed. The newly written code stays pending for the next frame boundary, 20 cycles later.
- R8: Over 200 cycles that start at a frame boundary, `tick` gives 100, 130, 160 and 190 pulses for codes 00, 01, 10 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe for the rate code |
| wr_sel | input | 2 | Rate code to write |
| idle | input | 1 | High when downstream logic may switch rate |
| tick | output | 1 | Clock-enable pulse train |
| rate_cur | output | 2 | Code of the active rate |
| upd_ack | output | 1 | One-cycle pulse when a new code takes effect |

## Verification
A software write and the commit of an earlier pending code can fall in the same cycle, on the last cycle of a frame. The bench provokes this by holding `idle` low after a first write. It then raises `idle` and writes a second code exactly in frame position 19. The bench expects the acknowledge on the next cycle with the first code active. It expects a second acknowledge with the second code exactly 20 cycles later. A behavioural reference model, compared on every cycle, judges `tick`, `rate_cur` and `upd_ack` throughout.

// File: rtl/rate_enable_gen.sv
module rate_enable_gen #(
  parameter int FRAME = 20,
  parameter int K0    = 10,
  parameter int K1    = 13,
  parameter int K2    = 16,
  parameter int K3    = 19
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic       idle,
  output logic       tick,
  output logic [1:0] rate_cur,
  output logic       upd_ack
);
  localparam int AW = $clog2(2 * FRAME);
  localparam int PW = $clog2(FRAME);

  logic [AW-1:0] acc, step, sum;
  logic [PW-1:0] pos;
  logic          pend;
  logic [1:0]    pend_sel;
  logic          last, commit;

  always_comb begin
    case (rate_cur)
      2'd0:    step = AW'(K0);
      2'd1:    step = AW'(K1);
      2'd2:    step = AW'(K2);
      default: step = AW'(K3);
    endcase
  end

  assign sum    = acc + step;
  assign tick   = sum >= AW'(FRAME);
  assign last   = pos == PW'(FRAME - 1);
  assign commit = last && idle && pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      pos      <= '0;
      rate_cur <= 2'd0;
      pend     <= 1'b0;
      pend_sel <= 2'd0;
      upd_ack  <= 1'b0;
    end else begin
      if (commit)    acc <= '0;
      else if (tick) acc <= sum - AW'(FRAME);
      else           acc <= sum;
      pos     <= last ? '0 : pos + 1'b1;
      upd_ack <= commit;
      if (commit) rate_cur <= pend_sel;
      if (wr_en) begin
        pend     <= 1'b1;
        pend_sel <= wr_sel;
      end else if (commit) begin
        pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rate_enable_gen_chk.sv
module rate_enable_gen_chk #(
  parameter int FRAME = 20,
  parameter int K0    = 10,
  parameter int K1    = 13,
  parameter int K2    = 16,
  parameter int K3    = 19,
  parameter int PW    = $clog2(FRAME)
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic [1:0]    rate_cur,
  input logic          upd_ack,
  input logic          idle,
  input logic [PW-1:0] pos
);
  logic       live;
  logic [7:0] ftk;
  int         kexp;

  always_comb begin
    case (rate_cur)
      2'd0:    kexp = K0;
      2'd1:    kexp = K1;
      2'd2:    kexp = K2;
      default: kexp = K3;
    endcase
  end

  always_ff @(posedge clk) begin
    live <= !rst;
    if (pos == '0) ftk <= {7'd0, tick};
    else           ftk <= ftk + {7'd0, tick};
  end

  assert_no_double_gap_R3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> tick);

  assert_frame_count_R2: assert property (@(posedge clk) disable iff (rst)
    (live && pos == PW'(FRAME - 1)) |-> (int'(ftk) + int'(tick) == kexp));

  assert_ack_single_R6: assert property (@(posedge clk) disable iff (rst)
    upd_ack |=> !upd_ack);

  assert_ack_at_boundary_R5: assert property (@(posedge clk) disable iff (rst)
    upd_ack |-> pos == '0);

  assert_ack_needs_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (live && upd_ack) |-> $past(idle));

  assert_rate_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (live && !upd_ack) |-> $stable(rate_cur));
endmodule

bind rate_enable_gen rate_enable_gen_chk #(
  .FRAME(FRAME), .K0(K0), .K1(K1), .K2(K2), .K3(K3)
) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .rate_cur(rate_cur),
  .upd_ack(upd_ack), .idle(idle), .pos(pos)
);

// File: tb/rate_enable_gen_bench.sv
`timescale 1ns/1ps
module rate_enable_gen_bench;
  logic clk = 1'b0;
  logic rst, wr_en, idle;
  logic [1:0] wr_sel;
  logic tick, upd_ack;
  logic [1:0] rate_cur;

  int total = 0, bad = 0;
  int kt[4] = '{10, 13, 16, 19};
  int m_acc, m_pos, m_rate, m_pend, m_psel, m_ack;
  bit m_ok = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rate_enable_gen u_rate_enable_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .idle(idle),
    .tick(tick), .rate_cur(rate_cur), .upd_ack(upd_ack)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_acc = 0; m_pos = 0; m_rate = 0; m_pend = 0; m_psel = 0; m_ack = 0; m_ok = 1;
    end else if (m_ok) begin
      bit c;
      int s;
      c = (m_pos == 19) && idle && (m_pend != 0);
      s = m_acc + kt[m_rate];
      m_acc = c ? 0 : (s >= 20 ? s - 20 : s);
      m_pos = (m_pos + 1) % 20;
      m_ack = c;
      if (c) m_rate = m_psel;
      if (wr_en) begin m_pend = 1; m_psel = wr_sel; end
      else if (c) m_pend = 0;
    end
  end

  always @(negedge clk) begin
    if (m_ok && !rst && !done) begin
      int et;
      et = (m_acc + kt[m_rate]) >= 20;
      chk(tick == et, "R3 tick vs model", tick, et);
      chk(rate_cur == m_rate, "R5 rate_cur vs model", rate_cur, m_rate);
      chk(upd_ack == m_ack, "R6 upd_ack vs model", upd_ack, m_ack);
    end
  end

  task automatic do_reset();
    @(posedge clk); #1 rst = 1; wr_en = 0;
    @(posedge clk); #1 rst = 0;
  endtask

  task automatic wr(input int s);
    @(posedge clk); #1 wr_en = 1; wr_sel = 2'(s);
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic wait_ack(input string tag, output int cyc);
    cyc = 0;
    @(negedge clk);
    while (!upd_ack && cyc < 60) begin @(negedge clk); cyc++; end
    chk(upd_ack == 1, tag, upd_ack, 1);
  endtask

  initial begin
    int n, cyc;
    rst = 1; wr_en = 0; wr_sel = 0; idle = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(rate_cur == 0, "R1 reset rate", rate_cur, 0);
    chk(upd_ack == 0, "R1 reset ack", upd_ack, 0);
    chk(tick == 0, "R1 first tick", tick, 0);

    for (int s = 0; s < 4; s++) begin
      do_reset(); idle = 1;
      wr(s);
      wait_ack("R6 ack after write", cyc);
      chk(rate_cur == s, "R2 loaded code", rate_cur, s);
      n = 0;
      for (int i = 0; i < 200; i++) begin
        n += tick;
        @(negedge clk);
      end
      chk(n == 10 * kt[s], "R8 pulses in 200 cycles", n, 10 * kt[s]);
    end

    do_reset(); idle = 0;
    wr(3);
    n = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); n += upd_ack; end
    chk(n == 0, "R5 no ack while busy", n, 0);
    chk(rate_cur == 0, "R5 rate held while busy", rate_cur, 0);
    @(posedge clk); #1 idle = 1;
    wait_ack("R5 commit once idle", cyc);
    chk(rate_cur == 3, "R5 rate after idle", rate_cur, 3);

    do_reset(); idle = 0;
    wr(1); wr(2);
    @(posedge clk); #1 idle = 1;
    wait_ack("R4 commit", cyc);
    chk(rate_cur == 2, "R4 latest write wins", rate_cur, 2);
    n = 0;
    for (int i = 0; i < 45; i++) begin @(negedge clk); n += upd_ack; end
    chk(n == 0, "R4 pending cleared", n, 0);

    do_reset(); idle = 0;
    wr(1);
    @(negedge clk);
    while (m_pos != 18) @(negedge clk);
    @(posedge clk); #1 idle = 1; wr_en = 1; wr_sel = 2'd2;
    @(posedge clk); #1 wr_en = 0;
    @(negedge clk);
    chk(upd_ack == 1, "R7 ack of older code", upd_ack, 1);
    chk(rate_cur == 1, "R7 older code committed", rate_cur, 1);
    wait_ack("R7 second ack", cyc);
    chk(cyc + 1 == 20, "R7 second commit spacing", cyc + 1, 20);
    chk(rate_cur == 2, "R7 newer code committed", rate_cur, 2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule